// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into an absolute address. It reads two entries from translation tables held in memory. The first entry comes from a segment table, whose origin is taken from a table designation supplied with the request. That entry locates a page table. The second entry, from the page table, holds the real page frame. The frame is joined to the byte offset of the virtual address to form the real address.

A prefix relocation then turns the real address into an absolute address. Real page zero and the processor's own prefix page swap places, and every other page passes through unchanged. This lets each processor in a shared-memory system keep its own low-storage page.

The block handles one walk at a time. It reads through a simple request/valid memory port that may stall for any number of cycles. It ends every walk with a single-cycle completion pulse that carries either the absolute address or a fault. The fault code says whether the segment entry or the page entry was invalid.

Top module: `xlat_walker`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, busy, mem_req, done and fault are all 0.
- R2: The virtual address splits into three fields. Bits [11:0] are the byte offset, bits [19:12] are the page index, and bits [31:20] are the segment index.
- R3: The first read goes to address {req_desig[31:2],2'b00} + 4 × segment index. Bits [1:0] of the designation are ignored. The read is issued on the cycle after the request is accepted.
- R4: If the segment entry has bit 0 clear, the second read goes to address {seg_entry[31:2],2'b00} + 4 × page index.
- R5: If the page entry has bit 0 clear, the real address is {page_entry[31:12], offset}. Page-entry bits [11:0] other than the invalid bit are ignored.
- R6: Prefix relocation works on the real frame number. Frame 0 becomes prefix_frame, and frame equal to prefix_frame becomes 0. Any other frame is unchanged.
- R7: A segment entry with bit 0 set ends the walk without a page read. It gives fault=1, fault_code=0 and abs_addr=0 on the done cycle.
- R8: A page entry with bit 0 set gives fault=1, fault_code=1 and abs_addr=0 on the done cycle.
- R9: mem_req stays asserted, with mem_addr unchanged, through every cycle until mem_rvalid is seen, whatever the number of stall cycles.
- R10: busy is 1 from the cycle after acceptance through the done cycle. While busy, req_valid is ignored and does not change the addresses read or the result.
- R11: done is high for exactly one cycle per walk. It comes two cycles after the page entry is returned, or one cycle after an invalid segment entry is returned. busy is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| req_valid | input | 1 | Start a walk; taken only when idle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_desig | input | 32 | Segment-table designation; bits [31:2] are the table origin |
| prefix_frame | input | 20 | Frame number of this processor's prefix page |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 32 | Byte address of the table entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table entry; bit 0 is the invalid flag |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Translation exception, valid with done |
| fault_code | output | 1 | 0 = segment entry invalid, 1 = page entry invalid |
| abs_addr | output | 32 | Absolute address, valid with done and no fault |

## Verification
The hardest case to reach from the ports is a new request, or a stray data return, arriving while a read is stalled. The block must ignore it and keep presenting the original entry address. The bench acts as the memory itself. It holds off mem_rvalid for a varying number of cycles and pulses req_valid with a different address during every stall. It then checks that the held address and the final result still belong to the first walk. A sweep over segment and page indices rotates the real frame through all three prefix cases: page zero, the prefix page itself, and an ordinary page.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEG  = 3'd1,
    ST_PAGE = 3'd2,
    ST_PFX  = 3'd3,
    ST_DONE = 3'd4
  } walk_st_e;

  typedef enum logic {
    FLT_SEG  = 1'b0,
    FLT_PAGE = 1'b1
  } flt_code_e;

  localparam int unsigned ENTRY_SHIFT = 2;  // 4-byte table entries
  localparam int unsigned INV_BIT     = 0;  // invalid flag position in an entry

endpackage

// File: rtl/xlat_entry_addr.sv
module xlat_entry_addr #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IDX_W = 8
) (
  input  logic [AW-1:0]    origin_raw,
  input  logic [IDX_W-1:0] index,
  output logic [AW-1:0]    entry_addr
);
  import xlat_pkg::*;

  localparam int unsigned SH = ENTRY_SHIFT;

  logic [AW-1:0] base;
  logic [AW-1:0] scaled;

  always_comb begin
    base   = {origin_raw[AW-1:SH], {SH{1'b0}}};
    scaled = AW'(index) << SH;
    entry_addr = base + scaled;
  end

endmodule

// File: rtl/xlat_prefix.sv
module xlat_prefix #(
  parameter int unsigned FRM_W = 20
) (
  input  logic [FRM_W-1:0] real_frm,
  input  logic [FRM_W-1:0] pfx_frm,
  output logic [FRM_W-1:0] abs_frm
);

  logic is_zero;
  logic is_pfx;

  always_comb begin
    is_zero = (real_frm == '0);
    is_pfx  = (real_frm == pfx_frm);
    if (is_zero)     abs_frm = pfx_frm;
    else if (is_pfx) abs_frm = '0;
    else             abs_frm = real_frm;
  end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PIX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [PA_W-1:0]       req_desig,
  input  logic [PA_W-OFF_W-1:0] prefix_frame,
  output logic                  busy,
  output logic                  mem_req,
  output logic [PA_W-1:0]       mem_addr,
  input  logic                  mem_rvalid,
  input  logic [PA_W-1:0]       mem_rdata,
  output logic                  done,
  output logic                  fault,
  output logic                  fault_code,
  output logic [PA_W-1:0]       abs_addr
);
  import xlat_pkg::*;

  localparam int unsigned SIX_W = VA_W - OFF_W - PIX_W;
  localparam int unsigned FRM_W = PA_W - OFF_W;
  localparam int unsigned PIX_LO = OFF_W;
  localparam int unsigned SIX_LO = OFF_W + PIX_W;

  walk_st_e         st_q, st_d;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  dsg_q;
  logic [PA_W-1:0]  pto_q;
  logic [FRM_W-1:0] frm_q;
  logic [FRM_W-1:0] abs_q;
  logic             flt_q, flt_d;
  logic             code_q, code_d;

  logic cap_req, cap_pto, cap_frm, cap_abs, cap_flt;

  logic [SIX_W-1:0] seg_idx;
  logic [PIX_W-1:0] pg_idx;
  logic [PA_W-1:0]  seg_addr;
  logic [PA_W-1:0]  pg_addr;
  logic [FRM_W-1:0] abs_frm;
  logic             entry_bad;

  assign seg_idx   = va_q[VA_W-1:SIX_LO];
  assign pg_idx    = va_q[SIX_LO-1:PIX_LO];
  assign entry_bad = mem_rdata[INV_BIT];

  xlat_entry_addr #(.AW(PA_W), .IDX_W(SIX_W)) i_seg_addr (
    .origin_raw (dsg_q),
    .index      (seg_idx),
    .entry_addr (seg_addr)
  );

  xlat_entry_addr #(.AW(PA_W), .IDX_W(PIX_W)) i_pg_addr (
    .origin_raw (pto_q),
    .index      (pg_idx),
    .entry_addr (pg_addr)
  );

  xlat_prefix #(.FRM_W(FRM_W)) i_prefix (
    .real_frm (frm_q),
    .pfx_frm  (prefix_frame),
    .abs_frm  (abs_frm)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cap_req = 1'b0;
    cap_pto = 1'b0;
    cap_frm = 1'b0;
    cap_abs = 1'b0;
    cap_flt = 1'b0;
    flt_d   = 1'b0;
    code_d  = code_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d    = ST_SEG;
          cap_req = 1'b1;
        end
      end
      ST_SEG: begin
        if (mem_rvalid) begin
          if (entry_bad) begin
            st_d    = ST_DONE;
            cap_flt = 1'b1;
            flt_d   = 1'b1;
            code_d  = FLT_SEG;
          end else begin
            st_d    = ST_PAGE;
            cap_pto = 1'b1;
          end
        end
      end
      ST_PAGE: begin
        if (mem_rvalid) begin
          if (entry_bad) begin
            st_d    = ST_DONE;
            cap_flt = 1'b1;
            flt_d   = 1'b1;
            code_d  = FLT_PAGE;
          end else begin
            st_d    = ST_PFX;
            cap_frm = 1'b1;
          end
        end
      end
      ST_PFX: begin
        st_d    = ST_DONE;
        cap_abs = 1'b1;
        cap_flt = 1'b1;
        flt_d   = 1'b0;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // state and datapath registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      va_q   <= '0;
      dsg_q  <= '0;
      pto_q  <= '0;
      frm_q  <= '0;
      abs_q  <= '0;
      flt_q  <= 1'b0;
      code_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cap_req) begin
        va_q  <= req_vaddr;
        dsg_q <= req_desig;
      end
      if (cap_pto) pto_q <= mem_rdata;
      if (cap_frm) frm_q <= mem_rdata[PA_W-1:OFF_W];
      if (cap_abs) abs_q <= abs_frm;
      if (cap_flt) begin
        flt_q  <= flt_d;
        code_q <= code_d;
      end
    end
  end

  // outputs
  always_comb begin
    busy       = (st_q != ST_IDLE);
    mem_req    = (st_q == ST_SEG) || (st_q == ST_PAGE);
    mem_addr   = (st_q == ST_PAGE) ? pg_addr : seg_addr;
    done       = (st_q == ST_DONE);
    fault      = done && flt_q;
    fault_code = code_q;
    abs_addr   = (done && !flt_q) ? {abs_q, va_q[OFF_W-1:0]} : '0;
  end

  // checks
  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !mem_req));

  a_r10_start_by_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  a_r7_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (abs_addr == '0));

  a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (abs_addr[OFF_W-1:0] == va_q[OFF_W-1:0]));

endmodule

// File: tb/test_xlat_walker.sv
`timescale 1ns/1ps
module test_xlat_walker;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [31:0] req_desig;
  logic [19:0] prefix_frame;
  logic        busy;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        done;
  logic        fault;
  logic        fault_code;
  logic [31:0] abs_addr;

  int nchk;
  int nfail;
  bit finished;

  xlat_walker i_xlat_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .req_desig    (req_desig),
    .prefix_frame (prefix_frame),
    .busy         (busy),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .done         (done),
    .fault        (fault),
    .fault_code   (fault_code),
    .abs_addr     (abs_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] relocate(input logic [19:0] f,
                                           input logic [19:0] p);
    if (f == 20'd0)  return p;
    else if (f == p) return 20'd0;
    else             return f;
  endfunction

  // Drives one walk, acting as the memory. st1/st2 are the stall cycles.
  task automatic walk(input logic [31:0] va, input logic [31:0] dsg,
                      input logic [31:0] sent, input logic [31:0] pent,
                      input int st1, input int st2, input logic [19:0] pfx);
    logic [31:0] sa;
    logic [31:0] pa;
    logic [31:0] ea;
    sa = {dsg[31:2], 2'b00} + ({20'd0, va[31:20]} << 2);
    pa = {sent[31:2], 2'b00} + ({24'd0, va[19:12]} << 2);
    ea = {relocate(pent[31:12], pfx), va[11:0]};
    prefix_frame = pfx;
    req_valid = 1'b1;
    req_vaddr = va;
    req_desig = dsg;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = ~va;
    req_desig = ~dsg;
    chk(busy && mem_req, "R10 busy after accept", {30'd0, busy, mem_req}, 32'h3);
    chk(mem_addr == sa, "R2 R3 segment entry address", mem_addr, sa);
    for (int i = 0; i < st1; i++) begin
      req_valid = 1'b1;               // stray request while busy
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_req && mem_addr == sa, "R9 R10 held segment read", mem_addr, sa);
    end
    mem_rvalid = 1'b1;
    mem_rdata  = sent;
    @(negedge clk);
    mem_rvalid = 1'b0;
    mem_rdata  = 32'hDEAD_BEEF;
    if (sent[0]) begin
      chk(done && fault && !fault_code && !mem_req, "R7 segment fault",
          {28'd0, done, fault, fault_code, mem_req}, 32'hC);
      chk(abs_addr == 32'd0, "R7 no address on fault", abs_addr, 32'd0);
      @(negedge clk);
      chk(!busy && !done, "R11 idle after fault", {30'd0, busy, done}, 32'd0);
      return;
    end
    chk(mem_req && !done && mem_addr == pa, "R2 R4 page entry address", mem_addr, pa);
    for (int i = 0; i < st2; i++) begin
      mem_rvalid = 1'b0;
      req_valid  = 1'b1;
      @(negedge clk);
      req_valid  = 1'b0;
      chk(mem_req && mem_addr == pa, "R9 R10 held page read", mem_addr, pa);
    end
    mem_rvalid = 1'b1;
    mem_rdata  = pent;
    @(negedge clk);
    mem_rvalid = 1'b0;
    mem_rdata  = 32'h1234_5678;
    chk(busy && !done && !mem_req, "R11 relocation cycle", {29'd0, busy, done, mem_req}, 32'h4);
    @(negedge clk);
    if (pent[0]) begin
      // invalid page entry: done already came on the previous cycle
      return;
    end
    chk(done && !fault, "R11 done without fault", {30'd0, done, fault}, 32'h2);
    chk(abs_addr == ea, "R5 R6 absolute address", abs_addr, ea);
    @(negedge clk);
    chk(!busy && !done, "R11 idle after done", {30'd0, busy, done}, 32'd0);
  endtask

  // Page-entry fault walk
  task automatic walk_pfault(input logic [31:0] va, input logic [31:0] dsg,
                             input logic [31:0] sent, input logic [31:0] pent);
    req_valid = 1'b1;
    req_vaddr = va;
    req_desig = dsg;
    @(negedge clk);
    req_valid = 1'b0;
    mem_rvalid = 1'b1;
    mem_rdata  = sent;
    @(negedge clk);
    mem_rdata  = pent;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk(done && fault && fault_code, "R8 page fault", {29'd0, done, fault, fault_code}, 32'h7);
    chk(abs_addr == 32'd0, "R8 no address on fault", abs_addr, 32'd0);
    @(negedge clk);
    chk(!busy && !done, "R11 idle after page fault", {30'd0, busy, done}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    nchk = 0;
    nfail = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_desig = '0;
    prefix_frame = 20'h000A5;
    mem_rvalid = 1'b0;
    mem_rdata = '0;
    @(negedge clk);
    @(negedge clk);
    chk(!busy && !mem_req && !done && !fault, "R1 reset state",
        {28'd0, busy, mem_req, done, fault}, 32'd0);
    rst_n = 1'b1;
    // a stray return while idle must not start anything
    mem_rvalid = 1'b1;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk(!busy && !mem_req && !done && !fault, "R1 after release",
        {28'd0, busy, mem_req, done, fault}, 32'd0);

    // sweep over segment / page indices and the three relocation cases
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 8; p++) begin
        logic [11:0] sx;
        logic [7:0]  px;
        logic [19:0] pfx;
        logic [19:0] frm;
        logic [31:0] va;
        logic [31:0] dsg;
        logic [31:0] sent;
        logic [31:0] pent;
        int k;
        k   = s * 8 + p;
        sx  = (s == 7) ? 12'hFFF : 12'(s * 517);
        px  = (p == 7) ? 8'hFF : 8'(p * 37);
        pfx = 20'h000A5 + 20'(s);
        case (k % 3)
          0:       frm = 20'd0;
          1:       frm = pfx;
          default: frm = 20'h80000 | 20'(k * 16 + 3);
        endcase
        va   = {sx, px, 12'(k * 61 + 7)};
        dsg  = 32'h0010_0000 + 32'(k << 14) + 32'h2;
        sent = 32'h0400_0000 + 32'(k << 10) + 32'h2;
        pent = {frm, 12'h7FE};
        walk(va, dsg, sent, pent, k % 4, (k + 1) % 5, pfx);
      end
    end

    // invalid segment entries
    walk(32'hABC1_2345, 32'h0020_0000, 32'h0800_0001, 32'h0, 2, 0, 20'h00010);
    walk(32'h0000_0FFF, 32'h0000_0003, 32'hFFFF_FFFF, 32'h0, 0, 0, 20'h00010);
    // invalid page entries
    walk_pfault(32'h1234_5678, 32'h0030_0000, 32'h0900_0000, 32'h0000_1001);
    walk_pfault(32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF);
    // a good walk after faults, with prefix page zero
    walk(32'h0050_3ABC, 32'h0040_0000, 32'h0A00_0000, 32'h0000_0000, 1, 1, 20'h00000);
    walk(32'h0050_3ABC, 32'h0040_0000, 32'h0A00_0000, 32'h0003_3000, 0, 3, 20'h00000);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule